// File: doc/BRIEF.md
# Calendar Shadow Register Synchronizer

This block sits between the calendar counters of a slow real-time clock domain and a fast bus-clock domain. In the slow domain it takes a snapshot of the sub-second, time and date counters every `REQ_DIV` slow cycles. A toggle then carries the snapshot into the bus domain, where all three bus-side shadow copies are loaded in the same bus cycle. Each load raises a sync flag. The flag tells software that the shadows hold a fresh and mutually consistent copy.

Software can clear the flag and then wait for it to be raised again. This is needed after leaving a low-power mode, after leaving initialization mode and after a sub-second shift request. While low-power mode or initialization mode is active, no loads happen. In a bypass mode, reads of the calendar registers return the live counter values, and each such read costs one wait state. The shadows and the flag are reset by the system reset. The control bits are reset only by the backup-domain reset, and so is the slow-domain snapshot logic.

Register word offsets on the bus: 0x00 sub-second, 0x04 time, 0x08 date, 0x0C control (bit 0 bypass, bit 1 init), 0x10 status (bit 0 sync flag), 0x14 shift request.

Top module: `cal_shadow_sync`

## Requirements
- R1: One load copies the sub-second, time and date shadows together, all from a single snapshot of the counters, and sets the sync flag (status 0x10 bit 0). A read of offsets 0x00/0x04/0x08 with bypass at 0 returns these shadows.
- R2: While neither low-power mode nor init is active, loads keep repeating every `REQ_DIV` slow cycles. After software clears the flag, the flag is raised again and the shadows keep advancing.
- R3: Writing status with bit 0 = 0 clears the flag. Writing bit 0 = 1 has no effect. If a load happens in the same cycle as the clear, the load wins.
- R4: While `lp_mode_i` is 1 there are no loads, the shadows are frozen and a cleared flag stays clear. A flag that was already set stays set. After `lp_mode_i` falls, the flag is raised only by a load that happens after the exit.
- R5: A system reset sets the three shadows and the flag to 0 and drops any pending wait state. After the reset, the flag stays 0 until a fresh load.
- R6: While control bit 1 (init) is 1, the flag is held at 0 and no loads happen. After init returns to 0, the flag is raised only by a new load.
- R7: Any write to offset 0x14 pulses `shift_req_o` for the access cycle and clears the flag.
- R8: With control bit 0 (bypass) at 1, reads of offsets 0x00/0x04/0x08 return the live counter values, zero-extended.
- R9: With bypass at 1, each calendar read holds `pready` low for exactly one cycle. All other reads and all writes complete with no wait.
- R10: The control register is cleared only by `bkp_rst_n`. A system reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | System reset, synchronous, active low (shadows, flag, wait state) |
| bkp_rst_n | input | 1 | Backup-domain reset, synchronous, active low (control bits, slow-domain logic) |
| rtc_clk | input | 1 | Slow calendar clock |
| lp_mode_i | input | 1 | Low-power mode indication, bus-clock synchronous |
| live_ss_i | input | SS_W | Live sub-second counter |
| live_time_i | input | TIME_W | Live time counter |
| live_date_i | input | DATE_W | Live date counter |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when 1 |
| paddr | input | 5 | Byte address, word index in bits 4:2 |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer completes when 1 |
| shift_req_o | output | 1 | One-cycle sub-second shift request to the calendar logic |

## Verification
The bench uses the default widths (16-bit sub-second, 24-bit time and date), `REQ_DIV` of 2 and two-stage synchronizers. The slow clock runs ten times slower than the bus clock, so a load lands about every twenty bus cycles. That makes it possible to tell frozen shadows apart from advancing ones within a few hundred cycles. The bench drives the live counters with a fixed relationship between them (time is three times the sub-second value, date is sub-second XOR 0x5A5A), so every shadow read also checks coherence. It can pause the counters so that bypass reads have one exact expected value.

// File: rtl/cal_sync_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the calendar shadow synchronizer: register word
// indices on the bus and the fixed byte-address width.
package cal_sync_pkg;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_SS    = 3'd0,
        SEL_TIME  = 3'd1,
        SEL_DATE  = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_STAT  = 3'd4,
        SEL_SHIFT = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/cal_sync_chain.sv
`timescale 1ns/1ps
// Multi-flop synchronizer, STAGES deep, W bits wide.
// Assumes: each bit is a level or toggle that stays put long enough to be
// caught; no multi-bit coherence is promised.
module cal_sync_chain #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] q_r;
        if (g == 0) begin : g_first
            // first capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
        end else begin : g_next
            // further metastability filter flop
            always_ff @(posedge clk) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= g_stage[g-1].q_r;
            end
        end
    end

    assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/cal_snap_src.sv
`timescale 1ns/1ps
// Slow-domain half: every REQ_DIV slow cycles, while neither low-power nor
// init mode is active, captures the three live counters into a snapshot and
// flips a toggle. Assumes the snapshot stays stable until the bus side has
// loaded it (bus clock several times faster than the slow clock).
module cal_snap_src #(
    parameter int unsigned SS_W        = 16,
    parameter int unsigned TIME_W      = 24,
    parameter int unsigned DATE_W      = 24,
    parameter int unsigned REQ_DIV     = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              rtc_clk,
    input  logic              bkp_rst_n,
    input  logic              lp_i,
    input  logic              init_i,
    input  logic [SS_W-1:0]   live_ss_i,
    input  logic [TIME_W-1:0] live_time_i,
    input  logic [DATE_W-1:0] live_date_i,
    output logic [SS_W-1:0]   snap_ss_o,
    output logic [TIME_W-1:0] snap_time_o,
    output logic [DATE_W-1:0] snap_date_o,
    output logic              tgl_o
);
    localparam int unsigned CNT_W = (REQ_DIV > 1) ? $clog2(REQ_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REQ_DIV - 1);

    logic [1:0]       mode_s;
    logic             run_s;
    logic [CNT_W-1:0] cnt_q;
    logic             tgl_q;
    logic [SS_W-1:0]   ss_q;
    logic [TIME_W-1:0] time_q;
    logic [DATE_W-1:0] date_q;

    cal_sync_chain #(.STAGES(SYNC_STAGES), .W(2)) u_mode_sync (
        .clk   (rtc_clk),
        .rst_n (bkp_rst_n),
        .d     ({lp_i, init_i}),
        .q     (mode_s)
    );

    assign run_s = ~mode_s[1] & ~mode_s[0];

    // divider, snapshot capture and toggle launch
    always_ff @(posedge rtc_clk) begin
        if (!bkp_rst_n) begin
            cnt_q  <= '0;
            tgl_q  <= 1'b0;
            ss_q   <= '0;
            time_q <= '0;
            date_q <= '0;
        end else if (!run_s) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            tgl_q  <= ~tgl_q;
            ss_q   <= live_ss_i;
            time_q <= live_time_i;
            date_q <= live_date_i;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign snap_ss_o   = ss_q;
    assign snap_time_o = time_q;
    assign snap_date_o = date_q;
    assign tgl_o       = tgl_q;

    // R4
    tgl_only_when_running_chk: assert property (@(posedge rtc_clk) disable iff (!bkp_rst_n)
        !$stable(tgl_q) |-> $past(run_s));
    // R1
    snap_moves_with_tgl_chk: assert property (@(posedge rtc_clk) disable iff (!bkp_rst_n)
        !$stable(ss_q) |-> !$stable(tgl_q));
endmodule

// File: rtl/cal_shadow_sink.sv
`timescale 1ns/1ps
// Bus-domain half: synchronizes the snapshot toggle, loads all three shadows
// in one cycle on each accepted toggle edge and keeps the sync flag.
// Assumes: edges are ignored for SYNC_STAGES+1 cycles after system reset so
// a stale toggle level never counts as a fresh load.
module cal_shadow_sink #(
    parameter int unsigned SS_W        = 16,
    parameter int unsigned TIME_W      = 24,
    parameter int unsigned DATE_W      = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              sys_rst_n,
    input  logic              tgl_i,
    input  logic [SS_W-1:0]   snap_ss_i,
    input  logic [TIME_W-1:0] snap_time_i,
    input  logic [DATE_W-1:0] snap_date_i,
    input  logic              load_en_i,
    input  logic              sw_clr_i,
    input  logic              force_clr_i,
    output logic [SS_W-1:0]   sh_ss_o,
    output logic [TIME_W-1:0] sh_time_o,
    output logic [DATE_W-1:0] sh_date_o,
    output logic              flag_o
);
    localparam int unsigned PRIME_END = SYNC_STAGES + 1;
    localparam int unsigned PR_W      = $clog2(PRIME_END + 1);

    logic            tgl_s;
    logic            last_q;
    logic [PR_W-1:0] prime_q;
    logic            primed;
    logic            load;
    logic            flag_q;
    logic [SS_W-1:0]   ss_q;
    logic [TIME_W-1:0] time_q;
    logic [DATE_W-1:0] date_q;

    cal_sync_chain #(.STAGES(SYNC_STAGES), .W(1)) u_tgl_sync (
        .clk   (pclk),
        .rst_n (sys_rst_n),
        .d     (tgl_i),
        .q     (tgl_s)
    );

    assign primed = (prime_q == PR_W'(PRIME_END));
    assign load   = primed && (tgl_s != last_q) && load_en_i;

    // edge tracking and post-reset priming window
    always_ff @(posedge pclk) begin
        if (!sys_rst_n) begin
            last_q  <= 1'b0;
            prime_q <= '0;
        end else begin
            last_q <= tgl_s;
            if (!primed) prime_q <= prime_q + 1'b1;
        end
    end

    // shadow load: all three fields in the same cycle
    always_ff @(posedge pclk) begin
        if (!sys_rst_n) begin
            ss_q   <= '0;
            time_q <= '0;
            date_q <= '0;
        end else if (load) begin
            ss_q   <= snap_ss_i;
            time_q <= snap_time_i;
            date_q <= snap_date_i;
        end
    end

    // sync flag: a load sets it and wins over any clear in the same cycle
    always_ff @(posedge pclk) begin
        if (!sys_rst_n)                 flag_q <= 1'b0;
        else if (load)                  flag_q <= 1'b1;
        else if (sw_clr_i || force_clr_i) flag_q <= 1'b0;
    end

    assign sh_ss_o   = ss_q;
    assign sh_time_o = time_q;
    assign sh_date_o = date_q;
    assign flag_o    = flag_q;

    // R1
    flag_rise_needs_load_chk: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        $rose(flag_q) |-> $past(load));
    // R1
    shadow_hold_chk: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        !$past(load) |-> ($stable(ss_q) && $stable(time_q) && $stable(date_q)));
    // R3
    flag_fall_cause_chk: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        $fell(flag_q) |-> $past(sw_clr_i || force_clr_i));
    // R4
    flag_stays_clear_chk: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        (!load_en_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/cal_bus_regs.sv
`timescale 1ns/1ps
// Bus register port: address decode, control bits (backup-reset domain),
// flag clear and shift strobes, and the one-cycle wait state for calendar
// reads in bypass mode. Assumes the bus holds an access stable until pready.
module cal_bus_regs
    import cal_sync_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SS_W   = 16,
    parameter int unsigned TIME_W = 24,
    parameter int unsigned DATE_W = 24
) (
    input  logic              pclk,
    input  logic              sys_rst_n,
    input  logic              bkp_rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    input  logic [SS_W-1:0]   sh_ss_i,
    input  logic [TIME_W-1:0] sh_time_i,
    input  logic [DATE_W-1:0] sh_date_i,
    input  logic [SS_W-1:0]   live_ss_i,
    input  logic [TIME_W-1:0] live_time_i,
    input  logic [DATE_W-1:0] live_date_i,
    input  logic              flag_i,
    output logic              bypass_o,
    output logic              init_o,
    output logic              sw_clr_o,
    output logic              shift_o
);
    reg_sel_e          sel;
    logic              acc;
    logic              cal_rd;
    logic              byp_rd;
    logic              wait_q;
    logic [DATA_W-1:0] live_q;
    logic [DATA_W-1:0] live_pick;
    logic              bypass_q;
    logic              init_q;
    logic              unused_bits;

    assign unused_bits = ^{pwdata[DATA_W-1:2], paddr[1:0]};
    assign sel    = reg_sel_e'(paddr[4:2]);
    assign acc    = psel & penable;
    assign cal_rd = acc & ~pwrite & (sel == SEL_SS || sel == SEL_TIME || sel == SEL_DATE);
    assign byp_rd = cal_rd & bypass_q;
    assign pready = ~(byp_rd & ~wait_q);

    // live counter selection for the bypass capture
    always_comb begin
        case (sel)
            SEL_SS:   live_pick = DATA_W'(live_ss_i);
            SEL_TIME: live_pick = DATA_W'(live_time_i);
            default:  live_pick = DATA_W'(live_date_i);
        endcase
    end

    // wait-state flop and live-value capture (system-reset domain)
    always_ff @(posedge pclk) begin
        if (!sys_rst_n) begin
            wait_q <= 1'b0;
            live_q <= '0;
        end else begin
            wait_q <= byp_rd & ~wait_q;
            if (byp_rd && !wait_q) live_q <= live_pick;
        end
    end

    // control bits, kept across system reset (backup-reset domain)
    always_ff @(posedge pclk) begin
        if (!bkp_rst_n) begin
            bypass_q <= 1'b0;
            init_q   <= 1'b0;
        end else if (acc && pwrite && sel == SEL_CTRL) begin
            bypass_q <= pwdata[0];
            init_q   <= pwdata[1];
        end
    end

    assign sw_clr_o = acc & pwrite & (sel == SEL_STAT) & ~pwdata[0];
    assign shift_o  = acc & pwrite & (sel == SEL_SHIFT);
    assign bypass_o = bypass_q;
    assign init_o   = init_q;

    // read data mux
    always_comb begin
        case (sel)
            SEL_SS:   prdata = bypass_q ? live_q : DATA_W'(sh_ss_i);
            SEL_TIME: prdata = bypass_q ? live_q : DATA_W'(sh_time_i);
            SEL_DATE: prdata = bypass_q ? live_q : DATA_W'(sh_date_i);
            SEL_CTRL: prdata = DATA_W'({init_q, bypass_q});
            SEL_STAT: prdata = DATA_W'(flag_i);
            default:  prdata = '0;
        endcase
    end

    // R9
    wait_one_cycle_chk: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        (acc && !pready) |=> pready);
    // R9
    write_no_wait_chk: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        (acc && pwrite) |-> pready);
endmodule

// File: rtl/cal_shadow_sync.sv
`timescale 1ns/1ps
// Top: calendar shadow synchronizer. Joins the slow-domain snapshot source,
// the bus-domain shadow sink and the bus register port. Assumes lp_mode_i is
// synchronous to pclk and that pclk is several times faster than rtc_clk.
module cal_shadow_sync
    import cal_sync_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SS_W        = 16,
    parameter int unsigned TIME_W      = 24,
    parameter int unsigned DATE_W      = 24,
    parameter int unsigned REQ_DIV     = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              sys_rst_n,
    input  logic              bkp_rst_n,
    input  logic              rtc_clk,
    input  logic              lp_mode_i,
    input  logic [SS_W-1:0]   live_ss_i,
    input  logic [TIME_W-1:0] live_time_i,
    input  logic [DATE_W-1:0] live_date_i,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              shift_req_o
);
    logic [SS_W-1:0]   snap_ss,   sh_ss;
    logic [TIME_W-1:0] snap_time, sh_time;
    logic [DATE_W-1:0] snap_date, sh_date;
    logic tgl, flag, bypass, init_mode, sw_clr, shift;

    cal_snap_src #(
        .SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W),
        .REQ_DIV(REQ_DIV), .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .rtc_clk     (rtc_clk),
        .bkp_rst_n   (bkp_rst_n),
        .lp_i        (lp_mode_i),
        .init_i      (init_mode),
        .live_ss_i   (live_ss_i),
        .live_time_i (live_time_i),
        .live_date_i (live_date_i),
        .snap_ss_o   (snap_ss),
        .snap_time_o (snap_time),
        .snap_date_o (snap_date),
        .tgl_o       (tgl)
    );

    cal_shadow_sink #(
        .SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_sink (
        .pclk        (pclk),
        .sys_rst_n   (sys_rst_n),
        .tgl_i       (tgl),
        .snap_ss_i   (snap_ss),
        .snap_time_i (snap_time),
        .snap_date_i (snap_date),
        .load_en_i   (~lp_mode_i & ~init_mode),
        .sw_clr_i    (sw_clr),
        .force_clr_i (shift | init_mode),
        .sh_ss_o     (sh_ss),
        .sh_time_o   (sh_time),
        .sh_date_o   (sh_date),
        .flag_o      (flag)
    );

    cal_bus_regs #(
        .DATA_W(DATA_W), .SS_W(SS_W), .TIME_W(TIME_W), .DATE_W(DATE_W)
    ) u_regs (
        .pclk        (pclk),
        .sys_rst_n   (sys_rst_n),
        .bkp_rst_n   (bkp_rst_n),
        .psel        (psel),
        .penable     (penable),
        .pwrite      (pwrite),
        .paddr       (paddr),
        .pwdata      (pwdata),
        .prdata      (prdata),
        .pready      (pready),
        .sh_ss_i     (sh_ss),
        .sh_time_i   (sh_time),
        .sh_date_i   (sh_date),
        .live_ss_i   (live_ss_i),
        .live_time_i (live_time_i),
        .live_date_i (live_date_i),
        .flag_i      (flag),
        .bypass_o    (bypass),
        .init_o      (init_mode),
        .sw_clr_o    (sw_clr),
        .shift_o     (shift)
    );

    assign shift_req_o = shift;

    // R6
    init_holds_flag_chk: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        $past(init_mode) && init_mode |-> !flag);
    // R10
    ctrl_kept_over_sys_reset_chk: assert property (@(posedge pclk) disable iff (!bkp_rst_n)
        !$past(psel && penable && pwrite && paddr[4:2] == 3'd3) |-> $stable(bypass));
endmodule

// File: tb/tb_cal_shadow_sync.sv
`timescale 1ns/1ps
module tb_cal_shadow_sync;
    localparam int DATA_W = 32;
    localparam logic [4:0] A_SS = 5'h00, A_TIME = 5'h04, A_DATE = 5'h08,
                           A_CTRL = 5'h0C, A_STAT = 5'h10, A_SHIFT = 5'h14;

    logic pclk = 0, rtc_clk = 0;
    logic sys_rst_n = 0, bkp_rst_n = 0;
    logic lp = 1;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [4:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic pready, shift_req;
    logic [31:0] n = 0;
    logic hold = 0;
    logic [15:0] live_ss;
    logic [23:0] live_time, live_date;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 pclk = ~pclk;
    always #20 rtc_clk = ~rtc_clk;

    // bench-side calendar counters with a fixed relation between fields
    always @(posedge rtc_clk) if (!hold) n <= n + 1;
    assign live_ss   = n[15:0];
    assign live_time = 24'(n * 3);
    assign live_date = 24'(n[15:0]) ^ 24'h5A5A;

    cal_shadow_sync dut (
        .pclk(pclk), .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n), .rtc_clk(rtc_clk),
        .lp_mode_i(lp), .live_ss_i(live_ss), .live_time_i(live_time), .live_date_i(live_date),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .shift_req_o(shift_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge pclk);
    endtask

    task automatic apb_read(input logic [4:0] a, output logic [31:0] d, output int w);
        w = 0;
        @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk); penable = 1; #1;
        while (!pready && w < 4) begin w++; @(negedge pclk); #1; end
        d = prdata;
        @(posedge pclk); #1; psel = 0; penable = 0;
    endtask

    task automatic apb_write(input logic [4:0] a, input logic [31:0] v, output bit shf, output int w);
        w = 0;
        @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = v; penable = 0;
        @(negedge pclk); penable = 1; #1;
        shf = shift_req;
        while (!pready && w < 4) begin w++; @(negedge pclk); #1; end
        @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        int w;
        apb_read(a, d, w);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        bit s; int w;
        apb_write(a, v, s, w);
    endtask

    task automatic wait_flag(input string tag);
        logic [31:0] d;
        int k = 0;
        d = 0;
        while (k < 100 && d[0] !== 1'b1) begin rd(A_STAT, d); k++; end
        check(tag, d[0], 1'b1);
    endtask

    task automatic check_coherent(input string tag);
        logic [31:0] s, t, dt;
        rd(A_SS, s); rd(A_TIME, t); rd(A_DATE, dt);
        check(tag, t, 32'(24'(s * 3)));
        check(tag, dt, 32'(24'(s[15:0]) ^ 24'h5A5A));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        idle(40); bkp_rst_n = 1; sys_rst_n = 1; idle(4);
        rd(A_SS, d);   check("R5 shadow zero after reset", d, 0);
        rd(A_STAT, d); check("R5 flag clear after reset", d, 0);
        rd(A_CTRL, d); check("R10 ctrl zero after backup reset", d, 0);
        idle(100);
        rd(A_STAT, d); check("R4 no flag while low-power", d, 0);
        lp = 0;
        wait_flag("R4 flag after low-power exit");
        check_coherent("R1 coherent shadows");
    endtask

    task automatic t_periodic();
        logic [31:0] a, b, d;
        rd(A_SS, a); idle(100); rd(A_SS, b);
        check("R2 shadows advance", 32'(b > a), 1);
        wr(A_STAT, 0);
        wait_flag("R2 flag re-raised after clear");
        check_coherent("R1 coherent after reload");
    endtask

    task automatic t_lowpower();
        logic [31:0] d, s0, s1;
        lp = 1; idle(10);
        rd(A_STAT, d); check("R4 set flag kept in low-power", d, 1);
        wr(A_STAT, 1);
        rd(A_STAT, d); check("R3 write one keeps flag set", d, 1);
        wr(A_STAT, 0);
        rd(A_STAT, d); check("R3 write zero clears flag", d, 0);
        wr(A_STAT, 1);
        rd(A_STAT, d); check("R3 write one does not set flag", d, 0);
        rd(A_SS, s0); idle(200); rd(A_SS, s1);
        check("R4 shadows frozen", s1, s0);
        rd(A_STAT, d); check("R4 flag stays clear", d, 0);
        lp = 0;
        wait_flag("R4 flag after exit");
        rd(A_SS, s1); check("R4 shadows moved after exit", 32'(s1 != s0), 1);
    endtask

    task automatic t_shift();
        logic [31:0] d; bit s; int w;
        lp = 1; idle(10);
        apb_write(A_SHIFT, 32'h1, s, w);
        check("R7 shift pulse", 32'(s), 1);
        idle(1);
        check("R7 shift pulse one cycle", 32'(shift_req), 0);
        rd(A_STAT, d); check("R7 shift clears flag", d, 0);
        lp = 0;
        wait_flag("R7 flag after shift");
    endtask

    task automatic t_init();
        logic [31:0] d, s0, s1;
        wr(A_CTRL, 32'h2);
        rd(A_STAT, d); check("R6 init clears flag", d, 0);
        rd(A_CTRL, d); check("R6 init bit readable", d, 2);
        rd(A_SS, s0); idle(200); rd(A_SS, s1);
        check("R6 no reload in init", s1, s0);
        rd(A_STAT, d); check("R6 flag held in init", d, 0);
        wr(A_CTRL, 0);
        wait_flag("R6 flag after init exit");
    endtask

    task automatic t_bypass();
        logic [31:0] d; int w; bit s;
        wr(A_CTRL, 32'h1);
        hold = 1; idle(100);
        apb_read(A_SS, d, w);
        check("R8 live sub-second", d, 32'(n[15:0]));
        check("R9 one wait on sub-second", 32'(w), 1);
        apb_read(A_TIME, d, w);
        check("R8 live time", d, 32'(24'(n * 3)));
        check("R9 one wait on time", 32'(w), 1);
        apb_read(A_DATE, d, w);
        check("R8 live date", d, 32'(24'(n[15:0]) ^ 24'h5A5A));
        apb_read(A_CTRL, d, w);
        check("R9 no wait on ctrl read", 32'(w), 0);
        apb_write(A_STAT, 32'h1, s, w);
        check("R9 no wait on write", 32'(w), 0);
        hold = 0;
        wr(A_CTRL, 0);
        apb_read(A_SS, d, w);
        check("R9 no wait without bypass", 32'(w), 0);
    endtask

    task automatic t_sysreset();
        logic [31:0] d;
        wr(A_CTRL, 32'h1);
        lp = 1; idle(5);
        sys_rst_n = 0; idle(5); sys_rst_n = 1; idle(2);
        rd(A_CTRL, d); check("R10 ctrl kept over system reset", d, 1);
        wr(A_CTRL, 0);
        rd(A_SS, d);   check("R5 shadow cleared by system reset", d, 0);
        rd(A_DATE, d); check("R5 date shadow cleared", d, 0);
        idle(100);
        rd(A_STAT, d); check("R5 flag clear until fresh load", d, 0);
        lp = 0;
        wait_flag("R5 flag after fresh load");
        wr(A_CTRL, 32'h3);
        bkp_rst_n = 0; idle(30); bkp_rst_n = 1; idle(2);
        rd(A_CTRL, d); check("R10 ctrl cleared by backup reset", d, 0);
    endtask

    initial begin
        t_reset();
        t_periodic();
        t_lowpower();
        t_shift();
        t_init();
        t_bypass();
        t_sysreset();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule